// File: doc/BRIEF.md
# Daisy-Chainable Converter Serial Port

This block is the device-side digital end of a sampling converter's three-wire serial link, built for daisy-chaining several converters. The host raises the convert strobe while the serial clock is low. That starts a modelled conversion and puts the port into chain mode. When the conversion timer expires, the port captures a parallel result word into its output shift register and puts the most significant bit on the serial output at once. From then on, each falling edge of the serial clock moves the word out one place.

The shift register's input is fed from the serial data input. That input comes from the next converter upstream. Once this port's own word has gone out, the upstream device's bits follow on the same wire, so a host reads N devices with N words' worth of clocks. The convert strobe, serial clock and serial data input are asynchronous to the system clock. They are synchronized and edge-detected on that clock rather than used as clocks. The port drops back to idle when the convert strobe falls.

Top module: `chain_adc_port`

## Requirements
- R1: After reset, the serial output and the acquisition flag are both 0.
- R2: While the convert strobe is low, the serial output is driven 0. This holds in particular when the serial data input is also low.
- R3: A convert-strobe rise seen while the serial clock is high starts nothing. The acquisition flag and the serial output stay 0 for as long as the strobe stays high.
- R4: A convert-strobe rise seen while the serial clock is low starts a conversion. The conversion lasts exactly CONV_CYCLES system clocks, and the acquisition flag stays 0 until it ends.
- R5: When the conversion ends, the acquisition flag goes to 1 and the serial output immediately shows bit 15 of the 16-bit result word.
- R6: Each serial-clock falling edge during readback shifts the register one place toward the output. The result goes out MSB first: bit 15, then 14, down to bit 0.
- R7: The serial data input level at each falling edge enters the register's low end. After the 16 own bits, the output repeats the input bits in the order they were clocked in.
- R8: Serial-clock edges during a conversion have no effect. The word later read out is the unaltered result.
- R9: A convert-strobe fall ends readback or aborts a conversion. The acquisition flag and the serial output return to 0, and an aborted conversion never raises the flag.
- R10: During readback, the serial output changes only after a serial-clock falling edge. It is therefore steady across both the rising and the falling edge of each clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe from host (asynchronous) |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| sdi_i | input | 1 | Serial data from the upstream device (asynchronous) |
| result_i | input | WORD_W | Parallel conversion result, captured when the conversion ends |
| sdo_o | output | 1 | Serial data toward the host or the downstream device |
| acq_o | output | 1 | High in the acquisition/power-down phase while readback is possible |

## Verification
The bench toggles the serial clock in the middle of a conversion. A port that did not gate those edges would shift a half-loaded or stale register and send a rotated word. It raises the strobe with the clock high, where a port that ignored the clock level would start a spurious conversion. It drops the strobe halfway through a conversion, where a timer that was not cleared would later raise the flag with no strobe present. Each readback runs past the 16 own bits to check that upstream bits pass through in order, and the output is sampled in both clock phases to catch data that moves on the rising edge.

// File: rtl/chain_port_pkg.sv
package chain_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_READ = 2'd2
    } port_state_e;
endpackage

// File: rtl/cpt_sync_edge.sv
// Multi-bit synchronizer followed by rise/fall detection on the settled level.
module cpt_sync_edge #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } se_t;

    se_t se_d, se_q;

    always_comb begin
        se_d         = se_q;
        se_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            se_d.pipe[s] = se_q.pipe[s-1];
        end
        se_d.prev = se_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) se_q <= '0;
        else        se_q <= se_d;
    end

    assign level_o = se_q.pipe[STAGES-1];

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_o[i] =  level_o[i] & ~se_q.prev[i];
        assign fall_o[i] = ~level_o[i] &  se_q.prev[i];
    end
endmodule

// File: rtl/cpt_conv_timer.sv
// Down-counter modelling conversion time; done_o marks the last cycle.
module cpt_conv_timer #(
    parameter int CYCLES = 40,
    localparam int CW    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (abort_i) begin
            t_d.busy = 1'b0;
        end else if (start_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CW'(CYCLES - 1);
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy_o = t_q.busy;
    assign done_o = t_q.busy && (t_q.cnt == '0);

    // R4: once running, the timer must reach zero before going idle unless aborted
    assert_timer_runs_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.busy && t_q.cnt != '0 && !abort_i) |=> t_q.busy);
endmodule

// File: rtl/cpt_chain_shreg.sv
// Output shift register: parallel load, serial shift toward the MSB, serial in at LSB.
module cpt_chain_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    input  logic         sin_i,
    output logic         msb_o
);
    typedef struct packed {
        logic [W-1:0] data;
    } sr_t;

    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)       sr_d.data = word_i;
        else if (shift_i) sr_d.data = {sr_q.data[W-2:0], sin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb_o = sr_q.data[W-1];

    // R6: a shift brings the next-lower bit to the output
    assert_shift_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> msb_o == $past(sr_q.data[W-2]));

    // R8: with neither load nor shift the output bit holds
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(msb_o));
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
    import chain_port_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int CONV_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [WORD_W-1:0] result_i,
    output logic              sdo_o,
    output logic              acq_o
);
    localparam int IDX_CNV = 0;
    localparam int IDX_SCK = 1;
    localparam int IDX_SDI = 2;
    localparam int NSIG    = 3;
    localparam int LW      = $clog2(CONV_CYCLES + 1);

    logic [NSIG-1:0] lvl, rise, fall;

    cpt_sync_edge #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sck_i, cnv_i}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    logic cnv_lvl, cnv_rise, sck_lvl, sck_fall, sdi_lvl;
    assign cnv_lvl  = lvl[IDX_CNV];
    assign cnv_rise = rise[IDX_CNV];
    assign sck_lvl  = lvl[IDX_SCK];
    assign sck_fall = fall[IDX_SCK];
    assign sdi_lvl  = lvl[IDX_SDI];

    typedef struct packed {
        port_state_e state;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tmr_start, tmr_abort, tmr_busy, tmr_done;
    logic sh_load, sh_shift, sh_msb;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cnv_rise && !sck_lvl) begin
                    tmr_start   = 1'b1;
                    ctl_d.state = ST_CONV;
                end
            end
            ST_CONV: begin
                if (!cnv_lvl) begin
                    tmr_abort   = 1'b1;
                    ctl_d.state = ST_IDLE;
                end else if (tmr_done) begin
                    sh_load     = 1'b1;
                    ctl_d.state = ST_READ;
                end
            end
            ST_READ: begin
                if (!cnv_lvl)      ctl_d.state = ST_IDLE;
                else if (sck_fall) sh_shift    = 1'b1;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE};
        else        ctl_q <= ctl_d;
    end

    cpt_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .abort_i (tmr_abort),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );

    cpt_chain_shreg #(.W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .word_i  (result_i),
        .shift_i (sh_shift),
        .sin_i   (sdi_lvl),
        .msb_o   (sh_msb)
    );

    assign acq_o = (ctl_q.state == ST_READ);
    assign sdo_o = acq_o & sh_msb;

    // Cycle count spent in conversion, used only by the R4 property
    logic [LW-1:0] conv_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     conv_len_q <= '0;
        else if (ctl_q.state == ST_CONV) conv_len_q <= conv_len_q + 1'b1;
        else                            conv_len_q <= '0;
    end

    assert_sdo_low_strobe_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_lvl |=> !sdo_o);

    assert_no_start_sck_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_IDLE && sck_lvl) |=> ctl_q.state != ST_CONV);

    assert_conv_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_CONV && tmr_done) |-> conv_len_q == LW'(CONV_CYCLES - 1));

    assert_timer_matches_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != ST_CONV) |-> !tmr_busy);

    assert_msb_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_CONV && tmr_done && cnv_lvl) |=>
            (acq_o && sdo_o == $past(result_i[WORD_W-1])));

    assert_flag_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv_lvl |=> !acq_o);

    assert_sdo_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_o && cnv_lvl && !sck_fall) |=> $stable(sdo_o));
endmodule

// File: tb/sim_chain_adc_port.sv
module sim_chain_adc_port;
    localparam int W  = 16;
    localparam int CC = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [W-1:0] res = '0;
    logic         sdo, acq;

    int n_run  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    chain_adc_port #(.WORD_W(W), .CONV_CYCLES(CC), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
        .result_i(res), .sdo_o(sdo), .acq_o(acq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected bit on the output after k falling edges: own word, then upstream stream
    function automatic bit exp_bit(input logic [W-1:0] own, input logic [W-1:0] up, input int k);
        if (k < W) return own[W-1-k];
        return up[2*W-1-k];
    endfunction

    task automatic run_frame(input logic [W-1:0] own, input logic [W-1:0] up, input bit jitter);
        cnv = 1'b0; sck = 1'b0; sdi = 1'b0;
        cyc(8);
        chk(sdo == 1'b0, "R2", sdo, 0);
        res = own;
        cnv = 1'b1;
        if (jitter) begin
            cyc(4);
            for (int p = 0; p < 2; p++) begin
                sck = 1'b1; cyc(3);
                sck = 1'b0; cyc(3);
            end
            cyc(9);
        end else begin
            cyc(25);
        end
        chk(acq == 1'b0, "R4 early", acq, 0);
        cyc(30);
        chk(acq == 1'b1, "R4/R5 flag", acq, 1);
        chk(sdo == own[W-1], "R5 msb", sdo, own[W-1]);
        for (int k = 0; k < 2*W - 1; k++) begin
            sdi = up[W-1-k % W];
            if (k >= W) sdi = 1'b0;
            if (k < W) sdi = up[W-1-k];
            sck = 1'b1;
            cyc(6);
            chk(sdo == exp_bit(own, up, k), "R10 high phase", sdo, exp_bit(own, up, k));
            sck = 1'b0;
            cyc(6);
            if (k + 1 < W)
                chk(sdo == exp_bit(own, up, k + 1), jitter ? "R6/R8 shift" : "R6 shift",
                    sdo, exp_bit(own, up, k + 1));
            else
                chk(sdo == exp_bit(own, up, k + 1), "R7 pass-through", sdo, exp_bit(own, up, k + 1));
        end
        sdi = 1'b0;
        cnv = 1'b0;
        cyc(6);
        chk(acq == 1'b0, "R9 flag", acq, 0);
        chk(sdo == 1'b0, "R9/R2 sdo", sdo, 0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7315);
        cyc(3);
        chk(sdo == 1'b0, "R1 sdo", sdo, 0);
        chk(acq == 1'b0, "R1 acq", acq, 0);
        rst_n = 1'b1;
        cyc(4);
        chk(sdo == 1'b0 && acq == 1'b0, "R1 after release", {sdo, acq}, 0);

        // R2: strobe low, data input high or low, output stays 0
        sdi = 1'b1; cyc(6);
        chk(sdo == 1'b0, "R2 sdi high", sdo, 0);
        sdi = 1'b0; cyc(6);
        chk(sdo == 1'b0, "R2 sdi low", sdo, 0);

        // Directed corners
        run_frame(16'hFFFF, 16'h0000, 1'b0);
        run_frame(16'h8001, 16'hA5C3, 1'b1);

        // R3: strobe rises with serial clock high
        sck = 1'b1; cyc(6);
        cnv = 1'b1; cyc(CC + 20);
        chk(acq == 1'b0, "R3 flag", acq, 0);
        chk(sdo == 1'b0, "R3 sdo", sdo, 0);
        cnv = 1'b0; cyc(4);
        sck = 1'b0; cyc(6);

        // R9: abort mid-conversion
        res = 16'hFFFF;
        cnv = 1'b1; cyc(15);
        cnv = 1'b0; cyc(CC + 20);
        chk(acq == 1'b0, "R9 abort flag", acq, 0);
        chk(sdo == 1'b0, "R9 abort sdo", sdo, 0);

        // Random frames
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            run_frame(a, b, 1'($urandom));
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule